// File: doc/BRIEF.md
# Host-Locked Sequence Local Lock Generator

This block drives the local-bus lock line for exclusive (atomic) sequences that a host-bus master starts toward the local address space. It watches the host frame and host lock strobes together with the region decode of the current host transaction. A locked host transaction that hits any local region arms the block. The lock line then drops in the same clock as the first local address strobe of the sequence. It stays asserted through every following local access, including gaps between accesses and host transactions that keep the host lock strobe asserted.

The lock line is released only when the host ends the locked transaction, which means host frame and host lock are both seen high in one clock. Even then, the line is held asserted for a programmable number of clocks after the last local access completes. While a sequence is armed or active, every mapped local region, the expansion ROM region among them, is reported as locked. A configuration enable turns the feature off. Locked host accesses then behave as ordinary ones and the lock line never moves.

Top module: `locked_seq_lock_gen`

## Requirements
- R1: While reset is held and after it is released, `lock_out_n` is 1 and `region_lock` is all zeros.
- R2: A clock in which `lock_en`=1, `host_frame_n`=0, `host_lock_n`=0 and any bit of `host_hit` is 1 arms a sequence. From the next clock `region_lock` is all ones, and `lock_out_n` stays 1 until the first `local_ads`.
- R3: `lock_out_n` goes to 0 in the same clock as the first `local_ads` after arming. The path from `local_ads` to `lock_out_n` is combinational.
- R4: Once asserted, `lock_out_n` stays 0 across any number of local accesses and the gaps between them. A clock with only `host_frame_n`=1, or only `host_lock_n`=1, does not release it.
- R5: Release needs a clock with `host_frame_n`=1 and `host_lock_n`=1. Let the last `local_done` be at clock t and that release clock be at r, where r is not earlier than the last `local_ads`. Then `lock_out_n` returns to 1 at clock max(t+HOLD_CYCLES, r)+1.
- R6: `region_lock` has all NREG bits set whenever `lock_out_n` is 0, whichever region the host hit.
- R7: With `lock_en`=0 no sequence is armed. `lock_out_n` stays 1 and `region_lock` stays zero through locked host accesses and local accesses.
- R8: A locked host transaction with `host_hit` all zeros does not arm, and `lock_out_n` stays 1.
- R9: If the release clock occurs while armed and before any `local_ads`, the block returns to idle. `lock_out_n` never asserts and `region_lock` clears on the next clock.
- R10: A single-clock local access, with `local_ads` and `local_done` in the same clock, starts the lock and its hold window in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_en | input | 1 | Enables locked operation for host-to-local accesses |
| host_frame_n | input | 1 | Host frame strobe, active low |
| host_lock_n | input | 1 | Host lock strobe, active low |
| host_hit | input | NREG | Decode of the host transaction against each local region |
| local_ads | input | 1 | Local address strobe, first clock of a local access |
| local_done | input | 1 | Final data clock of a local access |
| lock_out_n | output | 1 | Local lock line, active low |
| region_lock | output | NREG | Per-region locked flags |

## Verification
A sweep over every combination of enable, frame, lock and region hit in the arming clock separates the single arming pattern from the disabled, non-local and unlocked patterns, and each arming is followed by an immediate abort. Full sequences are swept over one to three accesses, access lengths of one to three clocks, gaps of zero to two clocks, arm-to-address delays of zero or one clock, and release offsets from before the last completion to well after the hold window. In every cycle the bench predicts the exact fall and rise clocks of the lock line. Host frame toggles with lock held low throughout each sequence, which shows that a frame-only end does not release. Whole sequences with the enable low or with no region hit confirm that the lock line does not move.

// File: rtl/locked_seq_lock_gen.sv
module locked_seq_lock_gen #(
  parameter int NREG        = 3,
  parameter int HOLD_CYCLES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lock_en,
  input  logic            host_frame_n,
  input  logic            host_lock_n,
  input  logic [NREG-1:0] host_hit,
  input  logic            local_ads,
  input  logic            local_done,
  output logic            lock_out_n,
  output logic [NREG-1:0] region_lock
);
  localparam int HW = $clog2(HOLD_CYCLES + 1) + 1;
  localparam logic [HW-1:0] HOLD_LD = HW'(HOLD_CYCLES);
  localparam logic [HW-1:0] ONE     = HW'(1);

  logic          armed_q, locked_q, busy_q, rel_q;
  logic [HW-1:0] hold_q;

  wire host_end = host_frame_n & host_lock_n;
  wire arm_req  = lock_en & ~host_frame_n & ~host_lock_n & (|host_hit);
  wire idle     = ~armed_q & ~locked_q;
  wire rel_seen = rel_q | host_end;
  wire quiet    = ~busy_q & ~local_ads & ~local_done & (hold_q <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
      busy_q   <= 1'b0;
      rel_q    <= 1'b0;
      hold_q   <= '0;
    end else if (idle) begin
      armed_q <= arm_req;
      rel_q   <= 1'b0;
      busy_q  <= 1'b0;
      hold_q  <= '0;
    end else if (armed_q) begin
      if (local_ads) begin
        armed_q  <= 1'b0;
        locked_q <= 1'b1;
        busy_q   <= ~local_done;
        hold_q   <= local_done ? HOLD_LD : '0;
        rel_q    <= host_end;
      end else if (host_end) begin
        armed_q <= 1'b0;
      end
    end else begin
      rel_q <= rel_seen;
      if (local_done) begin
        busy_q <= 1'b0;
        hold_q <= HOLD_LD;
      end else if (local_ads) begin
        busy_q <= 1'b1;
      end else if (!busy_q && hold_q != '0) begin
        hold_q <= hold_q - ONE;
      end
      if (rel_seen && quiet) begin
        locked_q <= 1'b0;
        rel_q    <= 1'b0;
        hold_q   <= '0;
      end
    end
  end

  assign lock_out_n  = ~(locked_q | (armed_q & local_ads));
  assign region_lock = {NREG{armed_q | locked_q}};

  assert_arm_covers_regions_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && arm_req) |=> (&region_lock));
  assert_lock_starts_on_ads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_out_n) |-> local_ads);
  assert_release_needs_host_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_out_n) |-> $past(rel_seen));
  assert_hold_after_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_out_n) |-> !$past(local_done));
  assert_all_regions_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_out_n |-> (&region_lock));
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !lock_en) |=> lock_out_n);
  assert_foreign_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && host_hit == '0) |=> lock_out_n);
endmodule

// File: tb/locked_seq_lock_gen_test.sv
module locked_seq_lock_gen_test;
  localparam int NREG = 3;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_en = 1'b1;
  logic host_frame_n = 1'b1;
  logic host_lock_n = 1'b1;
  logic [NREG-1:0] host_hit = '0;
  logic local_ads = 1'b0;
  logic local_done = 1'b0;
  logic lock_out_n;
  logic [NREG-1:0] region_lock;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  locked_seq_lock_gen #(.NREG(NREG), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en),
    .host_frame_n(host_frame_n), .host_lock_n(host_lock_n), .host_hit(host_hit),
    .local_ads(local_ads), .local_done(local_done),
    .lock_out_n(lock_out_n), .region_lock(region_lock)
  );

  always #2.5 clk = ~clk;

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected fewer than 150000", cycles);
      summary_and_end();
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s lock_out_n: got %0b expected %0b at t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic chkv(string tag, logic [NREG-1:0] got, logic [NREG-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s region_lock: got %b expected %b at t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic drive(logic en, logic fr, logic lk, logic [NREG-1:0] hit, logic ads, logic dn);
    @(negedge clk);
    lock_en = en; host_frame_n = fr; host_lock_n = lk; host_hit = hit;
    local_ads = ads; local_done = dn;
    #1;
  endtask

  task automatic idle_cycle();
    drive(1'b1, 1'b1, 1'b1, '0, 1'b0, 1'b0);
    chk("R5 idle", lock_out_n, 1'b1);
    chkv("R5 idle", region_lock, '0);
  endtask

  // R2 R3 R4 R5 R6 R10: full locked sequence, expected clocks computed from R5
  task automatic run_seq(int nacc, int len, int gap, int d, int roff);
    int s0, slast, tl, r, h, c_end;
    s0    = 1 + d;
    slast = s0 + (nacc - 1) * (len + gap);
    tl    = slast + len - 1;
    r     = tl - 1 + roff;
    if (r < slast) r = slast;
    h     = ((tl + HOLD) > r ? (tl + HOLD) : r) + 1;
    c_end = h + 2;
    for (int c = 0; c <= c_end; c++) begin
      logic fr, lk, ads, dn, exp_lock;
      logic [NREG-1:0] hit;
      string tag;
      ads = 1'b0; dn = 1'b0;
      for (int i = 0; i < nacc; i++) begin
        int si;
        si = s0 + i * (len + gap);
        if (c == si) ads = 1'b1;
        if (c == si + len - 1) dn = 1'b1;
      end
      hit = (c == 0) ? NREG'(1 << (nacc - 1)) : '0;
      fr  = (c == 0) ? 1'b0 : (c >= r) ? 1'b1 : logic'(c % 2);
      lk  = (c >= r) ? 1'b1 : 1'b0;
      drive(1'b1, fr, lk, hit, ads, dn);
      exp_lock = (c >= s0 && c < h) ? 1'b0 : 1'b1;
      if (c < s0)       tag = "R2";
      else if (c == s0) tag = (len == 1) ? "R10" : "R3";
      else if (c < h)   tag = "R4";
      else              tag = "R5";
      chk(tag, lock_out_n, exp_lock);
      chkv((c >= 1 && c < h) ? "R6" : tag, region_lock, (c >= 1 && c < h) ? '1 : '0);
    end
  endtask

  // R7 / R8: a whole sequence that must not lock
  task automatic run_blocked(logic en, logic [NREG-1:0] hit, string tag);
    for (int c = 0; c < 10; c++) begin
      logic fr, lk;
      fr = (c == 0) ? 1'b0 : (c >= 8) ? 1'b1 : logic'(c % 2);
      lk = (c >= 8) ? 1'b1 : 1'b0;
      drive(en, fr, lk, (c == 0) ? hit : '0, (c == 2 || c == 5), (c == 3 || c == 5));
      chk(tag, lock_out_n, 1'b1);
      chkv(tag, region_lock, '0);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk); #1;
      chk("R1", lock_out_n, 1'b1);
      chkv("R1", region_lock, '0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", lock_out_n, 1'b1);
    chkv("R1", region_lock, '0);

    // R2 R7 R8 R9: every arming-clock pattern, then immediate host end
    for (int k = 0; k < 16; k++) begin
      logic en, fr, lk, arms;
      logic [NREG-1:0] hit;
      string tag;
      en = k[3]; fr = k[2]; lk = k[1];
      hit = k[0] ? NREG'(1 << (k % NREG)) : '0;
      arms = en && !fr && !lk && k[0];
      tag = arms ? "R2" : (!en ? "R7" : (!k[0] ? "R8" : "R2"));
      drive(en, fr, lk, hit, 1'b0, 1'b0);
      chk(tag, lock_out_n, 1'b1);
      drive(1'b1, 1'b1, 1'b1, '0, 1'b0, 1'b0);
      chkv(tag, region_lock, arms ? '1 : '0);
      chk(tag, lock_out_n, 1'b1);
      drive(1'b1, 1'b1, 1'b1, '0, 1'b0, 1'b0);
      chkv("R9", region_lock, '0);
      chk("R9", lock_out_n, 1'b1);
    end

    run_blocked(1'b0, 3'b001, "R7");
    run_blocked(1'b1, '0, "R8");

    for (int nacc = 1; nacc <= 3; nacc++)
      for (int len = 1; len <= 3; len++)
        for (int gap = 0; gap <= 2; gap++)
          for (int d = 0; d <= 1; d++)
            for (int roff = 0; roff <= HOLD + 3; roff++) begin
              run_seq(nacc, len, gap, d, roff);
              idle_cycle();
            end

    summary_and_end();
  end
endmodule